// File: doc/BRIEF.md
# GPIO Port Interrupt Detection Unit

This unit watches the 32 pins of one GPIO port and turns selected pin activity into one interrupt request for an upstream interrupt controller. Each pin that is assigned to GPIO use and set as an input is checked against its own trigger condition. The four conditions are rising edge, falling edge, high level and low level. Every pin that matches raises a sticky bit in an event register. Software clears these bits by writing ones to them.

A mask register decides which event bits may drive the port request. The request is high while any event bit is both set and unmasked. The handler reads the event register and services the pins from bit 0 upward. Each pin input first passes through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier. Software reaches the registers through a simple word-wide write strobe and a combinational read port.

Top module: `gpio_irq_port`

## Requirements
- R1: With trigger code 0, a low-to-high change on an armed pin sets its event bit on the third rising clock edge after the change. A high-to-low change sets nothing.
- R2: With trigger code 1, a high-to-low change on an armed pin sets its event bit. A low-to-high change sets nothing.
- R3: With trigger code 2, the event bit sets while the synchronised pin is high. After a clear it sets again for as long as the pin stays high.
- R4: With trigger code 3, the event bit sets while the synchronised pin is low. It does not set while the pin is high.
- R5: Pins 0 to 15 take their 2-bit code from trigger register A (address 2). Pins 16 to 31 take theirs from trigger register B (address 3). Pin p uses bits [2*(p%16)+1 : 2*(p%16)].
- R6: Writing the event register (address 5) clears each bit written as 1. A bit written as 0 keeps its value.
- R7: If a new event and a clearing write hit the same bit on the same edge, the bit stays set.
- R8: A pin is armed only when its bit in the use register (address 0) is 1 and its bit in the direction register (address 1) is 0. A pin that is not armed never sets its event bit.
- R9: irq_o is high exactly when some event bit and its mask bit (address 4) are both 1.
- R10: Event bits latch even while masked. irq_o rises in the cycle after the mask write that unmasks a pending bit.
- R11: After reset, every register reads zero and irq_o is low.
- R12: The use, direction, trigger A, trigger B and mask registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 32 | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 use, 1 direction, 2 trigger A, 3 trigger B, 4 mask, 5 event |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Port interrupt request |

## Verification
A bad synchroniser or previous-value flop shows up as an event bit that sets a cycle early or late against the three-edge latency, or as a spurious edge on the wrong polarity. A wrong trigger-code slice shows up as an event on a neighbouring pin or on the other half of the port, as soon as that pin toggles. A fault in the event register shows up at reg_rdata and irq_o one cycle after the edge in question. Examples are a clear that wins over a new event, a bit that drops without a clearing write, or a bit on an unarmed pin.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int ADDR_W = 3;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        TRIG_RISE = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_LOW  = 2'd3
    } trig_e;

    typedef enum logic [ADDR_W-1:0] {
        SEL_USE   = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_TRIGA = 3'd2,
        SEL_TRIGB = 3'd3,
        SEL_MASK  = 3'd4,
        SEL_EVENT = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic now;
        logic last;
    } pin_samp_t;

    function automatic logic trig_hit(trig_e t, pin_samp_t s);
        case (t)
            TRIG_RISE: return  s.now & ~s.last;
            TRIG_FALL: return ~s.now &  s.last;
            TRIG_HIGH: return  s.now;
            default:   return ~s.now;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] now_o,
    output logic [NPINS-1:0] last_o
);
    logic [NPINS-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            now_o  <= '0;
            last_o <= '0;
        end else begin
            meta_q <= pin_i;
            now_o  <= meta_q;
            last_o <= now_o;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]          now_i,
    input  logic [NPINS-1:0]          last_i,
    input  logic [NPINS-1:0]          armed_i,
    input  logic [CODE_W*NPINS-1:0]   codes_i,
    output logic [NPINS-1:0]          evt_o
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_samp_t samp;
        trig_e     kind;
        always_comb begin
            samp.now  = now_i[p];
            samp.last = last_i[p];
            kind      = trig_e'(codes_i[CODE_W*p +: CODE_W]);
            evt_o[p]  = armed_i[p] & trig_hit(kind, samp);
        end
    end
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NPINS-1:0]          wdata,
    input  logic [NPINS-1:0]          evt_i,
    output logic [NPINS-1:0]          rdata,
    output logic [NPINS-1:0]          use_o,
    output logic [NPINS-1:0]          dir_o,
    output logic [CODE_W*NPINS-1:0]   codes_o,
    output logic [NPINS-1:0]          mask_o,
    output logic [NPINS-1:0]          status_o
);
    logic [NPINS-1:0] trig_a_q, trig_b_q;
    logic [NPINS-1:0] clr;
    reg_sel_e         sel;

    assign sel     = reg_sel_e'(addr);
    assign clr     = (we && sel == SEL_EVENT) ? wdata : '0;
    assign codes_o = {trig_b_q, trig_a_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            use_o    <= '0;
            dir_o    <= '0;
            trig_a_q <= '0;
            trig_b_q <= '0;
            mask_o   <= '0;
            status_o <= '0;
        end else begin
            if (we) begin
                case (sel)
                    SEL_USE:   use_o    <= wdata;
                    SEL_DIR:   dir_o    <= wdata;
                    SEL_TRIGA: trig_a_q <= wdata;
                    SEL_TRIGB: trig_b_q <= wdata;
                    SEL_MASK:  mask_o   <= wdata;
                    default:   ;
                endcase
            end
            status_o <= (status_o & ~clr) | evt_i;
        end
    end

    always_comb begin
        case (sel)
            SEL_USE:   rdata = use_o;
            SEL_DIR:   rdata = dir_o;
            SEL_TRIGA: rdata = trig_a_q;
            SEL_TRIGB: rdata = trig_b_q;
            SEL_MASK:  rdata = mask_o;
            SEL_EVENT: rdata = status_o;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              irq_o
);
    localparam int CODES_W = CODE_W * NPINS;

    logic [NPINS-1:0]   now_v, last_v;
    logic [NPINS-1:0]   use_v, dir_v, mask, status, armed, evt;
    logic [CODES_W-1:0] codes;

    gpio_irq_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst(rst), .pin_i(pin_i),
        .now_o(now_v), .last_o(last_v)
    );

    assign armed = use_v & ~dir_v;

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .now_i(now_v), .last_i(last_v), .armed_i(armed),
        .codes_i(codes), .evt_o(evt)
    );

    gpio_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .evt_i(evt), .rdata(reg_rdata),
        .use_o(use_v), .dir_o(dir_v), .codes_o(codes),
        .mask_o(mask), .status_o(status)
    );

    assign irq_o = |(status & mask);
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NPINS-1:0]  reg_wdata,
    input logic [NPINS-1:0]  evt,
    input logic [NPINS-1:0]  armed,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  mask,
    input logic              irq_o
);
    logic wr_evt;
    assign wr_evt = reg_we && (reg_addr == SEL_EVENT);

    // R7, R1: every detected event is present in the event register next cycle
    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(evt)) == $past(evt)));

    // R6: bits written as one with no concurrent event are cleared
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> ((status & $past(reg_wdata & ~evt)) == '0));

    // R6: without a clearing write no event bit drops
    a_r6_no_spurious_drop: assert property (@(posedge clk) disable iff (rst)
        !wr_evt |=> (($past(status) & ~status) == '0));

    // R8: an unarmed pin never raises its event bit
    a_r8_unarmed_quiet: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(armed)) == '0));

    // R9: with nothing unmasked the request stays low
    a_r9_masked_low: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq_o);

    // R9: an unmasked pending bit drives the request
    a_r9_pending_high: assert property (@(posedge clk) disable iff (rst)
        ((status & mask) != '0) |-> irq_o);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt(evt), .armed(armed), .status(status),
    .mask(mask), .irq_o(irq_o)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pins = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [2:0] A_USE = 3'd0, A_DIR = 3'd1, A_TA = 3'd2,
                           A_TB = 3'd3, A_MASK = 3'd4, A_EVT = 3'd5;

    always #4 clk = ~clk;

    gpio_irq_port u0 (
        .clk(clk), .rst(rst), .pin_i(pins), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic drive(input int p, input logic v);
        @(negedge clk);
        pins[p] = v;
        settle();
    endtask

    task automatic clean();
        settle();
        wr(A_EVT, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R11 reg zero after reset", v, 32'h0);
        end
        chk("R11 irq low after reset", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(A_USE, 32'hA5A5_0F0F);  rd(A_USE, v);  chk("R12 use", v, 32'hA5A5_0F0F);
        wr(A_DIR, 32'h1234_5678);  rd(A_DIR, v);  chk("R12 dir", v, 32'h1234_5678);
        wr(A_TA,  32'hDEAD_BEEF);  rd(A_TA, v);   chk("R12 trigA", v, 32'hDEAD_BEEF);
        wr(A_TB,  32'h0BAD_F00D);  rd(A_TB, v);   chk("R12 trigB", v, 32'h0BAD_F00D);
        wr(A_MASK, 32'h8000_0001); rd(A_MASK, v); chk("R12 mask", v, 32'h8000_0001);
        wr(A_TA, 0); wr(A_TB, 0); wr(A_MASK, 0); wr(A_DIR, 0);
        wr(A_USE, 32'hFFFF_FFFF);
        clean();
    endtask

    task automatic t_rising();
        logic [31:0] v;
        drive(3, 1'b1); rd(A_EVT, v); chk("R1 rise sets bit3", v, 32'h8);
        wr(A_EVT, 32'h8);
        drive(3, 1'b0); rd(A_EVT, v); chk("R1 fall ignored", v, 32'h0);
    endtask

    task automatic t_falling();
        logic [31:0] v;
        wr(A_TB, 32'h0000_0100);
        drive(20, 1'b1); rd(A_EVT, v); chk("R2 rise ignored", v, 32'h0);
        drive(20, 1'b0); rd(A_EVT, v); chk("R2 fall sets bit20", v, 32'h0010_0000);
        wr(A_TB, 0); clean();
    endtask

    task automatic t_high();
        logic [31:0] v;
        wr(A_TA, 32'h0000_0800);
        settle(); rd(A_EVT, v); chk("R3 low pin no event", v, 32'h0);
        drive(5, 1'b1); rd(A_EVT, v); chk("R3 high sets bit5", v, 32'h20);
        wr(A_EVT, 32'h20);
        @(negedge clk); rd(A_EVT, v); chk("R3 re-sets while high", v, 32'h20);
        drive(5, 1'b0); wr(A_EVT, 32'h20);
        rd(A_EVT, v); chk("R3 stays clear once low", v, 32'h0);
        wr(A_TA, 0); clean();
    endtask

    task automatic t_low();
        logic [31:0] v;
        drive(31, 1'b1); wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_TB, 32'hC000_0000);
        settle(); rd(A_EVT, v); chk("R4 high pin no event", v, 32'h0);
        drive(31, 1'b0); rd(A_EVT, v); chk("R4 low sets bit31", v, 32'h8000_0000);
        drive(31, 1'b1); wr(A_TB, 0);
        @(negedge clk); pins[31] = 1'b0;
        clean();
        rd(A_EVT, v); chk("R4 clean after low test", v, 32'h0);
    endtask

    task automatic t_placement();
        logic [31:0] v;
        wr(A_TB, 32'h0000_0001);
        @(negedge clk); pins[0] = 1'b1; pins[16] = 1'b1;
        settle(); rd(A_EVT, v); chk("R5 pin0 codeA rise, pin16 codeB fall", v, 32'h1);
        wr(A_EVT, 32'hFFFF_FFFF);
        @(negedge clk); pins[0] = 1'b0; pins[16] = 1'b0;
        settle(); rd(A_EVT, v); chk("R5 pin16 falls from trigB", v, 32'h0001_0000);
        wr(A_TB, 0); clean();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        @(negedge clk); pins[1] = 1'b1; pins[2] = 1'b1;
        settle(); rd(A_EVT, v); chk("R6 two events", v, 32'h6);
        wr(A_EVT, 32'h2); rd(A_EVT, v); chk("R6 one clears only bit1", v, 32'h4);
        wr(A_EVT, 32'h0); rd(A_EVT, v); chk("R6 zero write keeps", v, 32'h4);
        @(negedge clk); pins[1] = 1'b0; pins[2] = 1'b0;
        clean();
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk); pins[9] = 1'b1;
        @(negedge clk);
        wr(A_EVT, 32'h200);
        rd(A_EVT, v); chk("R7 event beats clear", v, 32'h200);
        @(negedge clk); pins[9] = 1'b0;
        clean();
    endtask

    task automatic t_gating();
        logic [31:0] v;
        wr(A_USE, 32'hFFFF_FBFF);
        drive(10, 1'b1); rd(A_EVT, v); chk("R8 not GPIO use", v, 32'h0);
        drive(10, 1'b0);
        wr(A_USE, 32'hFFFF_FFFF); wr(A_DIR, 32'h0000_0400);
        drive(10, 1'b1); rd(A_EVT, v); chk("R8 output pin", v, 32'h0);
        drive(10, 1'b0);
        wr(A_DIR, 0);
        drive(10, 1'b1); rd(A_EVT, v); chk("R8 armed pin", v, 32'h400);
        @(negedge clk); pins[10] = 1'b0;
        clean();
    endtask

    task automatic t_irq();
        logic [31:0] v;
        drive(4, 1'b1);
        rd(A_EVT, v); chk("R10 latched while masked", v, 32'h10);
        chk("R9 masked irq low", {31'b0, irq_o}, 32'h0);
        wr(A_MASK, 32'h0000_0020);
        chk("R9 other bit unmasked irq low", {31'b0, irq_o}, 32'h0);
        wr(A_MASK, 32'h0000_0010);
        chk("R10 unmask raises irq", {31'b0, irq_o}, 32'h1);
        wr(A_EVT, 32'h10);
        chk("R9 cleared irq low", {31'b0, irq_o}, 32'h0);
        @(negedge clk); pins[4] = 1'b0;
        wr(A_MASK, 0); clean();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_rising();
        t_falling();
        t_high();
        t_low();
        t_placement();
        t_w1c();
        t_collide();
        t_gating();
        t_irq();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule